// File: doc/BRIEF.md
# Zone-Based Access Protection Checker

This block decides, for a single memory access made while address translation is on, whether that access may go ahead. The translation stage supplies three things taken from the page entry that matched: a 4-bit zone index, an execute-enable bit and a write-enable bit. The checker keeps a 32-bit zone register that holds sixteen 2-bit zone codes. It uses the zone index to select one code. From that code, the privilege level of the access and its type (instruction fetch, data load or data store), it produces a permit signal. When an access is refused it also raises one of two violation flags: an instruction-side flag for fetches or a data-side flag for loads and stores.

The decision is combinational from the access inputs and the stored zone register. A write port loads a new value into the zone register on a clock edge, and that value governs decisions from the edge onward. When translation is off, the checker allows every access and raises no flag. Finding the page entry and delivering the fault to an interrupt controller are both handled outside this block.

Top module: `zone_guard`

## Requirements
- R1: While reset is asserted, and after it is released with no write, the zone register is all zeros, so every zone carries code 00.
- R2: On a rising clock edge with `cfg_wr_en` high, the zone register takes `cfg_wr_data`. Decisions use the new value from that edge on and use the old value before it. When `cfg_wr_en` is low the register keeps its value.
- R3: Zone z is taken from register bits [31-2z : 30-2z]. Zone 0 sits in bits [31:30] and zone 15 in bits [1:0].
- R4: Code 00 refuses every access from user mode (`acc_priv`=0). In privileged mode it applies the page rule of R8.
- R5: Code 01 applies the page rule of R8 in both privilege levels.
- R6: Code 10 applies the page rule of R8 in user mode and permits every access in privileged mode.
- R7: Code 11 permits every access in both privilege levels.
- R8: Page rule, with `acc_kind` encoded as 00 fetch, 01 load, 10 store, 11 load. A fetch is permitted only if `page_exec`=1. A store is permitted only if `page_write`=1. A load is always permitted.
- R9: With `xlate_on`=0, `acc_permit` is 1 and both violation flags are 0, whatever the zone code, privilege level, access type or page bits.
- R10: `fetch_fault` equals `acc_valid` AND NOT `acc_permit` AND (access is a fetch). `data_fault` equals `acc_valid` AND NOT `acc_permit` AND (access is a load or a store). The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Zone register write enable |
| cfg_wr_data | input | 32 | New zone register value |
| xlate_on | input | 1 | Translation enabled for this access |
| acc_valid | input | 1 | An access is being presented |
| acc_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| page_zone | input | 4 | Zone index from the matching page entry |
| page_exec | input | 1 | Page execute-enable |
| page_write | input | 1 | Page write-enable |
| acc_permit | output | 1 | Access may proceed |
| fetch_fault | output | 1 | Instruction-side violation |
| data_fault | output | 1 | Data-side violation |

## Verification
The case that is hardest to reach from the ports is a zone code that sits at one particular position in the register. The only way to see that position is through the zone index of an access, and the register itself cannot be read back. The stimulus therefore loads a sequence of register images. In some images zone k alone carries code 11 and every other zone carries 00. Others give each zone a code derived from its index, and some are pseudo-random. After each load, the bench sweeps every zone index, privilege level, access type and pair of page bits, in both translated and untranslated mode. Any field that is misplaced, swapped or shifted then shows up as a wrong permit on some specific zone.

// File: rtl/zg_pkg.sv
package zg_pkg;

  localparam int ZG_CODE_W = 2;

  typedef enum logic [1:0] {
    ACC_FETCH    = 2'b00,
    ACC_LOAD     = 2'b01,
    ACC_STORE    = 2'b10,
    ACC_LOAD_ALT = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    RULE_DENY = 2'b00,
    RULE_PAGE = 2'b01,
    RULE_OPEN = 2'b10
  } rule_e;

endpackage

// File: rtl/zg_zone_reg.sv
module zg_zone_reg #(
  parameter int          REG_W     = 32,
  parameter logic [31:0] RESET_VAL = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] zone_q
);

  logic [REG_W-1:0] zone_d;

  always_comb begin
    zone_d = zone_q;
    if (wr_en) zone_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zone_q <= RESET_VAL[REG_W-1:0];
    else        zone_q <= zone_d;
  end

  // R2: a write lands on the edge, otherwise the register holds
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> zone_q == $past(wr_data));
  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(zone_q));

endmodule

// File: rtl/zg_zone_sel.sv
module zg_zone_sel
  import zg_pkg::*;
#(
  parameter int NUM_ZONES = 16,
  parameter int ZSEL_W    = $clog2(NUM_ZONES),
  parameter int REG_W     = NUM_ZONES * ZG_CODE_W
) (
  input  logic [REG_W-1:0]     zone_q,
  input  logic [ZSEL_W-1:0]    sel,
  output logic [ZG_CODE_W-1:0] code
);

  localparam int SLOTS = 1 << ZSEL_W;

  logic [ZG_CODE_W-1:0] fields [SLOTS];

  // zone 0 in the most significant field, descending from there
  for (genvar z = 0; z < SLOTS; z++) begin : g_field
    if (z < NUM_ZONES) begin : g_used
      assign fields[z] = zone_q[REG_W-1-z*ZG_CODE_W -: ZG_CODE_W];
    end else begin : g_pad
      assign fields[z] = '0;
    end
  end

  always_comb code = fields[sel];

endmodule

// File: rtl/zg_rule.sv
module zg_rule
  import zg_pkg::*;
(
  input  logic [ZG_CODE_W-1:0] code,
  input  logic                 priv,
  output rule_e                rule
);

  always_comb begin
    unique case (code)
      2'b00:   rule = priv ? RULE_PAGE : RULE_DENY;
      2'b01:   rule = RULE_PAGE;
      2'b10:   rule = priv ? RULE_OPEN : RULE_PAGE;
      default: rule = RULE_OPEN;
    endcase
  end

endmodule

// File: rtl/zg_decide.sv
module zg_decide
  import zg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      xlate_on,
  input  logic      acc_valid,
  input  acc_kind_e kind,
  input  rule_e     rule,
  input  logic      page_exec,
  input  logic      page_write,
  output logic      permit,
  output logic      fetch_fault,
  output logic      data_fault
);

  logic page_ok;
  logic is_fetch;

  always_comb begin
    is_fetch = (kind == ACC_FETCH);
    unique case (kind)
      ACC_FETCH: page_ok = page_exec;
      ACC_STORE: page_ok = page_write;
      default:   page_ok = 1'b1;
    endcase
  end

  always_comb begin
    if (!xlate_on) begin
      permit = 1'b1;
    end else begin
      unique case (rule)
        RULE_DENY: permit = 1'b0;
        RULE_PAGE: permit = page_ok;
        default:   permit = 1'b1;
      endcase
    end
    fetch_fault = acc_valid && !permit && is_fetch;
    data_fault  = acc_valid && !permit && !is_fetch;
  end

  // R8: a fetch from a non-executable page under the page rule is refused
  a_r8_fetch_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_on && rule == RULE_PAGE && kind == ACC_FETCH && !page_exec) |-> !permit);
  // R10: at most one violation flag, and only for a presented access
  a_r10_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fetch_fault, data_fault}) <= 1);
  a_r10_fault_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_fault || data_fault) |-> acc_valid);

endmodule

// File: rtl/zone_guard.sv
module zone_guard
  import zg_pkg::*;
#(
  parameter int NUM_ZONES = 16,
  parameter int ZSEL_W    = $clog2(NUM_ZONES),
  parameter int REG_W     = NUM_ZONES * ZG_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic              xlate_on,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  input  logic [ZSEL_W-1:0] page_zone,
  input  logic              page_exec,
  input  logic              page_write,
  output logic              acc_permit,
  output logic              fetch_fault,
  output logic              data_fault
);

  logic [REG_W-1:0]     zone_q;
  logic [ZG_CODE_W-1:0] zone_code;
  rule_e                rule;

  zg_zone_reg #(.REG_W(REG_W), .RESET_VAL(32'h0)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .wr_data(cfg_wr_data),
    .zone_q (zone_q)
  );

  zg_zone_sel #(.NUM_ZONES(NUM_ZONES), .ZSEL_W(ZSEL_W), .REG_W(REG_W)) u_sel (
    .zone_q(zone_q),
    .sel   (page_zone),
    .code  (zone_code)
  );

  zg_rule u_rule (
    .code(zone_code),
    .priv(acc_priv),
    .rule(rule)
  );

  zg_decide u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .xlate_on   (xlate_on),
    .acc_valid  (acc_valid),
    .kind       (acc_kind_e'(acc_kind)),
    .rule       (rule),
    .page_exec  (page_exec),
    .page_write (page_write),
    .permit     (acc_permit),
    .fetch_fault(fetch_fault),
    .data_fault (data_fault)
  );

  // R9: untranslated accesses always pass with no violation
  a_r9_untranslated_open: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_on |-> (acc_permit && !fetch_fault && !data_fault));
  // R7: code 11 never refuses
  a_r7_open_code: assert property (@(posedge clk) disable iff (!rst_n)
    (zone_code == 2'b11) |-> acc_permit);
  // R4: code 00 refuses user accesses when translating
  a_r4_user_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_on && zone_code == 2'b00 && !acc_priv) |-> !acc_permit);

endmodule

// File: tb/zone_guard_bench.sv
module zone_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic        xlate_on, acc_valid, acc_priv, page_exec, page_write;
  logic [1:0]  acc_kind;
  logic [3:0]  page_zone;
  logic        acc_permit, fetch_fault, data_fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  zone_guard u_zone_guard (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .xlate_on(xlate_on), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_priv(acc_priv), .page_zone(page_zone), .page_exec(page_exec),
    .page_write(page_write), .acc_permit(acc_permit),
    .fetch_fault(fetch_fault), .data_fault(data_fault)
  );

  function automatic logic exp_permit(input logic [31:0] img, input logic [3:0] z,
                                      input logic xl, input logic pv, input logic [1:0] k,
                                      input logic ex, input logic wr);
    logic [1:0] c;
    logic pg;
    if (!xl) return 1'b1;
    c  = img[31-2*z -: 2];
    pg = (k == 2'b00) ? ex : (k == 2'b10) ? wr : 1'b1;
    case (c)
      2'b00:   return pv ? pg : 1'b0;
      2'b01:   return pg;
      2'b10:   return pv ? 1'b1 : pg;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic apply(input logic [3:0] z, input logic xl, input logic pv,
                       input logic [1:0] k, input logic ex, input logic wr);
    page_zone = z; xlate_on = xl; acc_priv = pv; acc_kind = k;
    page_exec = ex; page_write = wr; acc_valid = 1'b1;
    #1;
  endtask

  task automatic sweep(input logic [31:0] img);
    for (int z = 0; z < 16; z++)
      for (int xl = 0; xl < 2; xl++)
        for (int pv = 0; pv < 2; pv++)
          for (int k = 0; k < 4; k++)
            for (int ex = 0; ex < 2; ex++)
              for (int wr = 0; wr < 2; wr++) begin
                logic e, ef, ed;
                logic [1:0] c;
                string tag;
                apply(z[3:0], xl[0], pv[0], k[1:0], ex[0], wr[0]);
                e  = exp_permit(img, z[3:0], xl[0], pv[0], k[1:0], ex[0], wr[0]);
                ef = !e && (k == 0);
                ed = !e && (k != 0);
                c  = img[31-2*z -: 2];
                if (xl == 0)       tag = "R9";
                else if (c == 2'b00) tag = "R4,R8";
                else if (c == 2'b01) tag = "R5,R8";
                else if (c == 2'b10) tag = "R6,R8";
                else               tag = "R7";
                check(tag, "permit", acc_permit, e);
                check("R10", "fetch_fault", fetch_fault, ef);
                check("R10", "data_fault", data_fault, ed);
              end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] img, seed;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    xlate_on = 1'b1; acc_valid = 1'b0; acc_kind = 2'b01; acc_priv = 1'b0;
    page_zone = 4'd0; page_exec = 1'b0; page_write = 1'b0;
    repeat (3) @(negedge clk);
    apply(4'd5, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1);
    check("R1", "reset user load refused", acc_permit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    apply(4'd9, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1);
    check("R1", "post-reset user load refused", acc_permit, 1'b0);
    check("R1", "post-reset data fault", data_fault, 1'b1);
    apply(4'd9, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
    check("R1", "post-reset priv fetch exec page", acc_permit, 1'b1);
    sweep(32'h0);

    // R2: write timing and hold
    apply(4'd0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 32'hFFFF_FFFF;
    #2 check("R2", "before edge old value", acc_permit, 1'b0);
    @(posedge clk); #2;
    check("R2", "after edge new value", acc_permit, 1'b1);
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = 32'h0;
    @(posedge clk); #2;
    check("R2", "hold without enable", acc_permit, 1'b1);

    // R3: one zone open at a time
    for (int k = 0; k < 16; k++) begin
      img = 32'h3 << (30 - 2*k);
      write_reg(img);
      for (int z = 0; z < 16; z++) begin
        apply(z[3:0], 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
        check("R3", $sformatf("zone %0d of image %h", z, img), acc_permit, z == k);
      end
    end

    // full sweeps under several register images
    img = '0;
    for (int z = 0; z < 16; z++) img[31-2*z -: 2] = z[1:0];
    write_reg(img); sweep(img);
    img = '0;
    for (int z = 0; z < 16; z++) img[31-2*z -: 2] = z[3:2];
    write_reg(img); sweep(img);
    write_reg(32'h5555_5555); sweep(32'h5555_5555);
    write_reg(32'hAAAA_AAAA); sweep(32'hAAAA_AAAA);
    seed = 32'h1234_5678;
    for (int i = 0; i < 3; i++) begin
      seed = seed * 32'h0019_660D + 32'h3C6E_F35F;
      write_reg(seed); sweep(seed);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule